// File: doc/BRIEF.md
# Video DAC Host Control Register Bank

This block is the host-facing register bank of a true-colour video DAC. The CPU reaches it over a small synchronous bus. A 4-bit register code is built from two low address bits and two extra select lines. Local codes hold three command registers, a fourth command register that is reached indirectly, a fixed identification/status value, and 12-bit hardware-cursor X and Y positions. All other codes go unchanged to an external port that serves the classic palette, the extended colour and the cursor-pattern storage.

From the command registers the block decodes the settings that the rest of the display path needs. These are the DAC component width, the pixel depth in bits per pixel, cursor enable, cursor size, and the cursor origin on each axis. The origin is the programmed position less the current cursor edge length.

Top module: `dac_host_regs`

## Requirements
- R1: Codes 0, 1, 2, 3, 4, 5, 7 and 0xB are forwarded. `fwd_wr`/`fwd_rd` mirror `wr_en`/`rd_en` in the same cycle, with `fwd_code` equal to the code and `fwd_wdata` equal to `wdata`. No local setting changes. A forwarded read returns `fwd_rdata` on `rdata`.
- R2: Code 6 is command register 0 and reads back as written. Its bit 0 drives `dac_8bit` (1 = 8-bit components, 0 = 6-bit).
- R3: Code 8 is command register 1 and reads back as written. `pix_bpp` follows its field in bits 6:5. With field 0, it is 32 if bit 4 is set and 8 otherwise. With field 1 and bit 4 set, it is 16 if bit 3 is set and 15 if bit 3 is clear; with field 1 and bit 4 clear, it is 8. Field 2 gives 8 and field 3 gives 4.
- R4: Code 9 is command register 2. `cursor_en` is 1 exactly when its bit 0 or its bit 1 is set.
- R5: Code 0xA with command register 0 bit 7 clear reads 0x60, and writes there are ignored. With bit 7 set, code 0xA reads and writes command register 3.
- R6: Command register 3 bit 2 drives `cursor_big` (1 = 64x64 cursor, 0 = 32x32).
- R7: Cursor X takes its low byte at code 0xC and its bits 11:8 at code 0xD. Cursor Y uses codes 0xE and 0xF in the same way. A high write keeps only data bits 3:0. A read of a high code returns the upper four position bits with bits 7:4 zero.
- R8: `org_x`/`org_y` equal the position minus 64 (big) or 32 (small), as a 13-bit two's-complement value.
- R9: After reset: all command registers and positions are zero, `dac_8bit`=0, `pix_bpp`=8, `cursor_en`=0, `cursor_big`=0, and code 0xA reads 0x60.
- R10: `rdata` is registered. It carries the selected value in the cycle after `rd_en` and holds when `rd_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr_lo | input | 2 | CPU address bits, code bits 1:0 |
| ext_sel | input | 2 | Extra select lines, code bits 3:2 |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| fwd_wr | output | 1 | Forwarded write strobe |
| fwd_rd | output | 1 | Forwarded read strobe |
| fwd_code | output | 4 | Forwarded register code |
| fwd_wdata | output | 8 | Forwarded write data |
| fwd_rdata | input | 8 | Read data from the forwarded port |
| dac_8bit | output | 1 | 8-bit component mode |
| pix_bpp | output | 6 | Pixel depth in bits per pixel |
| cursor_en | output | 1 | Hardware cursor enable |
| cursor_big | output | 1 | 64x64 cursor selected |
| org_x | output | 13 | Cursor X origin, two's complement |
| org_y | output | 13 | Cursor Y origin, two's complement |

## Verification
The bench builds the block with its default parameters: 12-bit positions, cursor edges of 32 and 64, and a status value of 0x60. With these values, a position below the cursor size makes the origin negative, and a high-byte write with upper bits set shows that those bits are dropped. Because the cursor edges are two different powers of two, toggling the indirect size bit moves the origin by a known step.

// File: rtl/dac_host_pkg.sv
// Shared constants and decode helpers for the video DAC host register bank.
// Assumes a 4-bit register code of {ext_sel, addr_lo}.
package dac_host_pkg;
    localparam logic [3:0] CODE_CMD0   = 4'h6;
    localparam logic [3:0] CODE_CMD1   = 4'h8;
    localparam logic [3:0] CODE_CMD2   = 4'h9;
    localparam logic [3:0] CODE_SHARED = 4'hA;
    localparam logic [3:0] CODE_POS    = 4'hC;   // first position code; X lo, X hi, Y lo, Y hi follow
    localparam logic [15:0] LOCAL_MASK = 16'hF740;  // codes served inside this block

    // Pixel depth from command register 1 bits 6:3
    function automatic logic [5:0] depth_of(input logic [3:0] f);
        logic [5:0] d;
        case (f[3:2])
            2'd0:    d = f[1] ? 6'd32 : 6'd8;
            2'd1:    d = f[1] ? (f[0] ? 6'd16 : 6'd15) : 6'd8;
            2'd2:    d = 6'd8;
            default: d = 6'd4;
        endcase
        return d;
    endfunction
endpackage

// File: rtl/dac_sel_decode.sv
// Register code decoder: splits accesses between local registers and the
// forwarded port, and produces one write strobe per local register.
// Assumes wr_en and rd_en are single-cycle strobes.
module dac_sel_decode
    import dac_host_pkg::*;
#(
    parameter int AXES = 2
) (
    input  logic            wr_en,
    input  logic [3:0]      code,
    output logic            is_local,
    output logic            wr_cmd0,
    output logic            wr_cmd1,
    output logic            wr_cmd2,
    output logic            wr_shared,
    output logic [AXES-1:0] wr_lo,
    output logic [AXES-1:0] wr_hi
);
    // Local/forward split and command register strobes
    always_comb begin
        is_local  = LOCAL_MASK[code];
        wr_cmd0   = wr_en && (code == CODE_CMD0);
        wr_cmd1   = wr_en && (code == CODE_CMD1);
        wr_cmd2   = wr_en && (code == CODE_CMD2);
        wr_shared = wr_en && (code == CODE_SHARED);
    end

    // One low/high strobe pair per axis, at consecutive codes
    for (genvar a = 0; a < AXES; a++) begin : g_axis
        localparam logic [3:0] LO = CODE_POS + 4'(2 * a);
        assign wr_lo[a] = wr_en && (code == LO);
        assign wr_hi[a] = wr_en && (code == LO + 4'd1);
    end
endmodule

// File: rtl/dac_pos_reg.sv
// One cursor position register, written as a low byte and an upper part.
// Assumes 9 <= POS_W <= 16; upper data bits of a high write are dropped.
module dac_pos_reg #(
    parameter int POS_W = 12,
    localparam int HI_W = POS_W - 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_lo,
    input  logic             wr_hi,
    input  logic [7:0]       lo_data,
    input  logic [HI_W-1:0]  hi_data,
    output logic [POS_W-1:0] pos
);
    // Byte-lane update of the position
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos <= '0;
        end else begin
            if (wr_lo) pos[7:0]       <= lo_data;
            if (wr_hi) pos[POS_W-1:8] <= hi_data;
        end
    end
endmodule

// File: rtl/dac_mode_decode.sv
// Turns command register fields and positions into display-path settings.
// Purely combinational; assumes positions are unsigned.
module dac_mode_decode
    import dac_host_pkg::*;
#(
    parameter int POS_W     = 12,
    parameter int CUR_SMALL = 32,
    parameter int CUR_BIG   = 64
) (
    input  logic             mode_bit,
    input  logic [3:0]       depth_field,
    input  logic [1:0]       cur_ctl,
    input  logic             size_bit,
    input  logic [POS_W-1:0] pos_x,
    input  logic [POS_W-1:0] pos_y,
    output logic             dac_8bit,
    output logic [5:0]       pix_bpp,
    output logic             cursor_en,
    output logic             cursor_big,
    output logic [POS_W:0]   org_x,
    output logic [POS_W:0]   org_y
);
    logic [POS_W:0] edge_len;

    // Mode, depth, enable and origin derivation
    always_comb begin
        dac_8bit   = mode_bit;
        pix_bpp    = depth_of(depth_field);
        cursor_en  = |cur_ctl;
        cursor_big = size_bit;
        edge_len   = size_bit ? (POS_W+1)'(CUR_BIG) : (POS_W+1)'(CUR_SMALL);
        org_x      = {1'b0, pos_x} - edge_len;
        org_y      = {1'b0, pos_y} - edge_len;
    end
endmodule

// File: rtl/dac_host_regs.sv
// Top of the video DAC host register bank: command registers, indirect
// access to command register 3, status value, cursor positions, and
// forwarding of palette-side codes. Synchronous active-low reset.
module dac_host_regs
    import dac_host_pkg::*;
#(
    parameter int         POS_W     = 12,
    parameter int         CUR_SMALL = 32,
    parameter int         CUR_BIG   = 64,
    parameter logic [7:0] STATUS_ID = 8'h60
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic         rd_en,
    input  logic [1:0]   addr_lo,
    input  logic [1:0]   ext_sel,
    input  logic [7:0]   wdata,
    output logic [7:0]   rdata,
    output logic         fwd_wr,
    output logic         fwd_rd,
    output logic [3:0]   fwd_code,
    output logic [7:0]   fwd_wdata,
    input  logic [7:0]   fwd_rdata,
    output logic         dac_8bit,
    output logic [5:0]   pix_bpp,
    output logic         cursor_en,
    output logic         cursor_big,
    output logic [POS_W:0] org_x,
    output logic [POS_W:0] org_y
);
    localparam int AXES = 2;
    localparam int HI_W = POS_W - 8;

    logic [3:0]       sel_code;
    logic             is_local, wr_cmd0, wr_cmd1, wr_cmd2, wr_shared;
    logic [AXES-1:0]  wr_lo, wr_hi;
    logic [7:0]       cr0_q, cr1_q, cr2_q, cr3_q;
    logic [POS_W-1:0] pos_q [AXES];
    logic [7:0]       rd_mux;

    assign sel_code = {ext_sel, addr_lo};

    dac_sel_decode #(.AXES(AXES)) u_dec (
        .wr_en(wr_en), .code(sel_code), .is_local(is_local),
        .wr_cmd0(wr_cmd0), .wr_cmd1(wr_cmd1), .wr_cmd2(wr_cmd2),
        .wr_shared(wr_shared), .wr_lo(wr_lo), .wr_hi(wr_hi)
    );

    // Forwarded port: pass-through for every non-local code
    always_comb begin
        fwd_wr    = wr_en && !is_local;
        fwd_rd    = rd_en && !is_local;
        fwd_code  = sel_code;
        fwd_wdata = wdata;
    end

    // Command registers; register 3 only when unlocked by cr0 bit 7
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cr0_q <= '0;
            cr1_q <= '0;
            cr2_q <= '0;
            cr3_q <= '0;
        end else begin
            if (wr_cmd0)              cr0_q <= wdata;
            if (wr_cmd1)              cr1_q <= wdata;
            if (wr_cmd2)              cr2_q <= wdata;
            if (wr_shared && cr0_q[7]) cr3_q <= wdata;
        end
    end

    for (genvar a = 0; a < AXES; a++) begin : g_pos
        dac_pos_reg #(.POS_W(POS_W)) u_pos (
            .clk(clk), .rst_n(rst_n), .wr_lo(wr_lo[a]), .wr_hi(wr_hi[a]),
            .lo_data(wdata), .hi_data(wdata[HI_W-1:0]), .pos(pos_q[a])
        );
    end

    dac_mode_decode #(.POS_W(POS_W), .CUR_SMALL(CUR_SMALL), .CUR_BIG(CUR_BIG)) u_mode (
        .mode_bit(cr0_q[0]), .depth_field(cr1_q[6:3]), .cur_ctl(cr2_q[1:0]),
        .size_bit(cr3_q[2]), .pos_x(pos_q[0]), .pos_y(pos_q[1]),
        .dac_8bit(dac_8bit), .pix_bpp(pix_bpp), .cursor_en(cursor_en),
        .cursor_big(cursor_big), .org_x(org_x), .org_y(org_y)
    );

    // Read source selection by register code
    always_comb begin
        case (sel_code)
            CODE_CMD0:   rd_mux = cr0_q;
            CODE_CMD1:   rd_mux = cr1_q;
            CODE_CMD2:   rd_mux = cr2_q;
            CODE_SHARED: rd_mux = cr0_q[7] ? cr3_q : STATUS_ID;
            4'hC:        rd_mux = pos_q[0][7:0];
            4'hD:        rd_mux = {{(16-POS_W){1'b0}}, pos_q[0][POS_W-1:8]};
            4'hE:        rd_mux = pos_q[1][7:0];
            4'hF:        rd_mux = {{(16-POS_W){1'b0}}, pos_q[1][POS_W-1:8]};
            default:     rd_mux = fwd_rdata;
        endcase
    end

    // Registered read data, held between reads
    always_ff @(posedge clk) begin
        if (!rst_n)     rdata <= '0;
        else if (rd_en) rdata <= rd_mux;
    end
endmodule

// File: rtl/dac_host_regs_chk.sv
// Property checker for the DAC host register bank, bound to the top.
module dac_host_regs_chk #(
    parameter int POS_W = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [3:0]       sel,
    input logic [7:0]       wdata,
    input logic             fwd_wr,
    input logic [7:0]       cmd0,
    input logic [POS_W-1:0] pos_x,
    input logic             dac_8bit,
    input logic [5:0]       pix_bpp,
    input logic             cursor_en,
    input logic             cursor_big
);
    assert_fwd_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        fwd_wr |=> $stable(dac_8bit) && $stable(pix_bpp) && $stable(cursor_en) && $stable(cursor_big));

    assert_dac_mode_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel == 4'h6) |=> dac_8bit == $past(wdata[0]));

    assert_bpp_legal_R3: assert property (@(posedge clk) disable iff (!rst_n)
        pix_bpp inside {6'd4, 6'd8, 6'd15, 6'd16, 6'd32});

    assert_cursor_en_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel == 4'h9) |=> cursor_en == (|$past(wdata[1:0])));

    assert_status_lock_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel == 4'hA && !cmd0[7]) |=> $stable(cursor_big));

    assert_high_nibble_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel == 4'hD) |=> pos_x[POS_W-1:8] == $past(wdata[POS_W-9:0]));
endmodule

bind dac_host_regs dac_host_regs_chk #(.POS_W(POS_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .sel(sel_code), .wdata(wdata),
    .fwd_wr(fwd_wr), .cmd0(cr0_q), .pos_x(pos_q[0]), .dac_8bit(dac_8bit),
    .pix_bpp(pix_bpp), .cursor_en(cursor_en), .cursor_big(cursor_big)
);

// File: tb/sim_dac_host_regs.sv
// Directed bench for the DAC host register bank; one task per scenario.
module sim_dac_host_regs;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 1'b0, rd_en = 1'b0;
    logic [1:0] addr_lo = '0, ext_sel = '0;
    logic [7:0] wdata = '0, fwd_rdata = 8'h3C;
    logic [7:0] rdata, fwd_wdata;
    logic fwd_wr, fwd_rd, dac_8bit, cursor_en, cursor_big;
    logic [3:0] fwd_code;
    logic [5:0] pix_bpp;
    logic [12:0] org_x, org_y;
    int n_tests = 0, n_fail = 0;
    bit done = 0;

    always #10 clk = ~clk;   // 50 MHz

    dac_host_regs u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
        .addr_lo(addr_lo), .ext_sel(ext_sel), .wdata(wdata), .rdata(rdata),
        .fwd_wr(fwd_wr), .fwd_rd(fwd_rd), .fwd_code(fwd_code),
        .fwd_wdata(fwd_wdata), .fwd_rdata(fwd_rdata), .dac_8bit(dac_8bit),
        .pix_bpp(pix_bpp), .cursor_en(cursor_en), .cursor_big(cursor_big),
        .org_x(org_x), .org_y(org_y)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [3:0] c, input logic [7:0] d, output bit fwd);
        @(negedge clk);
        {ext_sel, addr_lo} = c; wdata = d; wr_en = 1'b1;
        #1 fwd = fwd_wr && (fwd_code == c) && (fwd_wdata == d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic bus_rd(input logic [3:0] c, output logic [7:0] d, output bit fwd);
        @(negedge clk);
        {ext_sel, addr_lo} = c; rd_en = 1'b1;
        #1 fwd = fwd_rd && (fwd_code == c);
        @(negedge clk);
        rd_en = 1'b0;
        d = rdata;
    endtask

    task automatic t_reset;
        logic [7:0] d; bit f;
        check("R9 dac_8bit", dac_8bit, 0);
        check("R9 pix_bpp", pix_bpp, 8);
        check("R9 cursor_en", cursor_en, 0);
        check("R9 cursor_big", cursor_big, 0);
        check("R9 org_x", org_x, 13'h1FE0);
        bus_rd(4'hA, d, f);
        check("R9 status at 0xA", d, 8'h60);
    endtask

    task automatic t_forward;
        logic [7:0] d; bit f;
        bus_wr(4'h1, 8'hFF, f);
        check("R1 write code 1 forwarded", f, 1);
        check("R1 no local effect", {dac_8bit, cursor_en, cursor_big}, 0);
        check("R1 depth untouched", pix_bpp, 8);
        bus_wr(4'hB, 8'h07, f);
        check("R1 write code 0xB forwarded", f, 1);
        fwd_rdata = 8'h5A;
        bus_rd(4'h7, d, f);
        check("R1 read code 7 forwarded", f, 1);
        check("R1 forwarded read data", d, 8'h5A);
        bus_wr(4'h6, 8'h00, f);
        check("R1 local code not forwarded", f, 0);
    endtask

    task automatic t_cmd0;
        logic [7:0] d; bit f;
        bus_wr(4'h6, 8'h01, f);
        check("R2 8-bit mode", dac_8bit, 1);
        bus_rd(4'h6, d, f);
        check("R2 readback", d, 8'h01);
        bus_wr(4'h6, 8'h00, f);
        check("R2 6-bit mode", dac_8bit, 0);
    endtask

    task automatic t_depth;
        logic [7:0] d; bit f;
        logic [7:0] v [8] = '{8'h10, 8'h00, 8'h38, 8'h30, 8'h20, 8'h40, 8'h50, 8'h60};
        int         e [8] = '{32, 8, 16, 15, 8, 8, 8, 4};
        for (int i = 0; i < 8; i++) begin
            bus_wr(4'h8, v[i], f);
            check($sformatf("R3 depth for 0x%0h", v[i]), pix_bpp, e[i]);
        end
        bus_rd(4'h8, d, f);
        check("R3 readback", d, 8'h60);
    endtask

    task automatic t_cursor_en;
        bit f;
        logic [7:0] v [4] = '{8'h01, 8'h02, 8'h03, 8'hFC};
        int         e [4] = '{1, 1, 1, 0};
        for (int i = 0; i < 4; i++) begin
            bus_wr(4'h9, v[i], f);
            check($sformatf("R4 enable for 0x%0h", v[i]), cursor_en, e[i]);
        end
    endtask

    task automatic t_shared;
        logic [7:0] d; bit f;
        bus_wr(4'hA, 8'h04, f);
        check("R5 locked write ignored", cursor_big, 0);
        bus_rd(4'hA, d, f);
        check("R5 locked read status", d, 8'h60);
        bus_wr(4'h6, 8'h80, f);
        bus_wr(4'hA, 8'h04, f);
        check("R6 64x64 selected", cursor_big, 1);
        bus_rd(4'hA, d, f);
        check("R5 unlocked readback", d, 8'h04);
        bus_wr(4'h6, 8'h00, f);
        bus_rd(4'hA, d, f);
        check("R5 relocked status", d, 8'h60);
        check("R6 size kept while locked", cursor_big, 1);
    endtask

    task automatic t_position;
        logic [7:0] d; bit f;
        bus_wr(4'hC, 8'h34, f);
        bus_wr(4'hD, 8'hF5, f);
        bus_wr(4'hE, 8'h12, f);
        bus_wr(4'hF, 8'h0A, f);
        bus_rd(4'hC, d, f); check("R7 X low", d, 8'h34);
        bus_rd(4'hD, d, f); check("R7 X high drops upper bits", d, 8'h05);
        bus_rd(4'hE, d, f); check("R7 Y low", d, 8'h12);
        bus_rd(4'hF, d, f); check("R7 Y high", d, 8'h0A);
        bus_wr(4'h9, 8'h00, f);
        check("R10 rdata held", rdata, 8'h0A);
    endtask

    task automatic t_origin;
        bit f;
        check("R8 X origin big", org_x, 1332 - 64);
        check("R8 Y origin big", org_y, 2578 - 64);
        bus_wr(4'h6, 8'h80, f);
        bus_wr(4'hA, 8'h00, f);
        check("R8 X origin small", org_x, 1332 - 32);
        bus_wr(4'hD, 8'h00, f);
        bus_wr(4'hC, 8'h0A, f);
        check("R8 negative origin", org_x, 13'h1FEA);
    endtask

    initial begin
        #4_000_000;
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_forward();
        t_cmd0();
        t_depth();
        t_cursor_en();
        t_shared();
        t_position();
        t_origin();
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule